// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an external byte-wide static RAM that has no clock of its own. The host hands over one single-beat request at a time (an address, a write flag and, for writes, one data byte) using a valid/ready pair. The controller then produces the chip-select, write-strobe and output-enable levels for the RAM, drives the address and write data, controls the tri-state enable of its own data driver, and returns read data with a one-cycle valid pulse.

Every timing limit of the memory is a parameter in nanoseconds, together with the system clock period. Each one is converted to a whole number of clock cycles by rounding up. A read keeps select and output enable low for as long as the slowest access path needs. A write first parks output enable high long enough for the RAM outputs to float. It then pulls the write strobe low for the longest of pulse width, data setup and the end-of-write limits. The write ends with one hold cycle in which the controller still drives the bus while the RAM is deselected. Between accesses the RAM stays deselected.

Top module: `asram_ctrl`

## Requirements
- R1: Out of reset and whenever no access is in progress, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are all 1, `sram_dq_oe` is 0, `rd_valid` is 0 and `req_ready` is 1.
- R2: A request is taken only on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle until the access completes, `req_ready` is 0, and a `req_valid` presented during that time starts nothing: the RAM pins keep the pattern of the running access and the RAM contents are not altered.
- R3: A read (`req_write` = 0) holds `sram_cs_n` = 0, `sram_oe_n` = 0, `sram_we_n` = 1 and `sram_dq_oe` = 0 for RDC cycles, starting the cycle after acceptance. RDC = ceil(max(T_RC, T_AA, T_ACS, T_OEA) / CLK_NS), at least 1.
- R4: The byte on `sram_dq_in` at the clock edge that ends the last read cycle appears on `rd_data` in the next cycle, with `rd_valid` = 1 for exactly that one cycle. `req_ready` returns to 1 in the same cycle.
- R5: A write (`req_write` = 1) starts with WSC setup cycles in which `sram_cs_n` = 0, `sram_oe_n` = 1, `sram_we_n` = 1 and `sram_dq_oe` = 0. WSC = ceil(T_OHZ / CLK_NS), at least 1.
- R6: WPC strobe cycles follow, with `sram_we_n` = 0, `sram_cs_n` = 0, `sram_oe_n` = 1 and `sram_dq_oe` = 1, and with `sram_dq_out` equal to the accepted write byte and unchanged throughout. WPC is the largest of ceil(T_WP/CLK_NS), ceil(T_DS/CLK_NS), ceil(T_AW/CLK_NS) − WSC, ceil(T_WC/CLK_NS) − WSC and 1.
- R7: After the strobe there is one hold cycle with `sram_we_n` = 1, `sram_cs_n` = 1 and `sram_dq_oe` still 1. In the cycle after that, `sram_dq_oe` is 0 and `req_ready` is 1, so a new request can be taken at once.
- R8: `sram_addr` equals the accepted address from the first cycle of an access to its last, and it never changes while `sram_cs_n` is 0.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0. `sram_we_n` is 0 only while `sram_cs_n` is 0 and `sram_oe_n` is 1, and it never falls in the same cycle as `sram_cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Request address |
| req_wdata | input | DATA_W (8) | Write byte |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | DATA_W (8) | Byte returned by a read |
| sram_addr | output | ADDR_W (19) | RAM address pins |
| sram_cs_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W (8) | Byte driven toward the RAM data pins |
| sram_dq_oe | output | 1 | Enable for the data pin driver |
| sram_dq_in | input | DATA_W (8) | Byte sampled from the RAM data pins |

## Verification
The bench builds the controller with a 12 ns clock and the fastest-grade limits. This makes 55 ns round up to 5 cycles and 25 ns and 50 ns round up to 3 and 5, so the rounding and the end-of-write subtraction are both exercised: RDC = 5, WSC = 2 and WPC = 4. The bench's RAM model returns a poison byte until output enable has been low for RDC cycles, so a read phase that is too short returns visibly wrong data. The model commits a write only when the strobe rises, which exposes a strobe that is too short or is misplaced.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WSETUP = 3'd2,
        ST_WPULSE = 3'd3,
        ST_WHOLD  = 3'd4
    } phase_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
        logic drv;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_PARKED = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drv: 1'b0};

    // nanoseconds to clock cycles, rounded up
    function automatic int ns_to_cyc(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max_of(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int read_cycles(int clk_ns, int t_rc, int t_aa, int t_acs, int t_oea);
        int worst;
        worst = max_of(max_of(t_rc, t_aa), max_of(t_acs, t_oea));
        return max_of(1, ns_to_cyc(worst, clk_ns));
    endfunction

    function automatic int setup_cycles(int clk_ns, int t_ohz);
        return max_of(1, ns_to_cyc(t_ohz, clk_ns));
    endfunction

    // strobe length: pulse width, data setup, and the two limits that
    // count from select low (the setup phase already covers part of them)
    function automatic int strobe_cycles(int clk_ns, int t_wp, int t_ds,
                                         int t_aw, int t_wc, int ws_cyc);
        int r;
        r = max_of(ns_to_cyc(t_wp, clk_ns), ns_to_cyc(t_ds, clk_ns));
        r = max_of(r, ns_to_cyc(t_aw, clk_ns) - ws_cyc);
        r = max_of(r, ns_to_cyc(t_wc, clk_ns) - ws_cyc);
        return max_of(1, r);
    endfunction

    function automatic pin_ctl_t pins_of(phase_e ph);
        pin_ctl_t p;
        p = PINS_PARKED;
        case (ph)
            ST_READ:   begin p.cs_n = 1'b0; p.oe_n = 1'b0; end
            ST_WSETUP: begin p.cs_n = 1'b0; end
            ST_WPULSE: begin p.cs_n = 1'b0; p.we_n = 1'b0; p.drv = 1'b1; end
            ST_WHOLD:  begin p.drv  = 1'b1; end
            default:   p = PINS_PARKED;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

    // R3/R6: a running phase counts down by exactly one per cycle
    a_r3_timer_step: assert property (@(posedge clk) disable iff (rst)
        (!load && !done) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/asram_fsm.sv
module asram_fsm
    import asram_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 6,
    parameter int WS_CYC = 2,
    parameter int WP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    output logic             ready,
    output logic             accept,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output logic             capture,
    output pin_ctl_t         pins
);

    phase_e   state_q, state_d;
    pin_ctl_t pins_q;

    always_comb begin
        state_d  = state_q;
        accept   = 1'b0;
        load     = 1'b0;
        load_val = '0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_write) begin
                        state_d  = ST_WSETUP;
                        load_val = CNT_W'(WS_CYC - 1);
                    end else begin
                        state_d  = ST_READ;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (phase_done) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WSETUP: begin
                if (phase_done) begin
                    state_d  = ST_WPULSE;
                    load     = 1'b1;
                    load_val = CNT_W'(WP_CYC - 1);
                end
            end
            ST_WPULSE: begin
                if (phase_done) begin
                    state_d = ST_WHOLD;
                end
            end
            ST_WHOLD: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // pins come straight from flops so the RAM never sees decode glitches
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            pins_q  <= PINS_PARKED;
        end else begin
            state_q <= state_d;
            pins_q  <= pins_of(state_d);
        end
    end

    assign ready = (state_q == ST_IDLE);
    assign pins  = pins_q;

    // R1: idle means the RAM is parked
    a_r1_idle_parked: assert property (@(posedge clk) disable iff (rst)
        ready |-> (pins_q == PINS_PARKED));

    // R9: own driver is never on while the RAM may drive
    a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
        pins_q.drv |-> pins_q.oe_n);

    // R9: strobe only inside a selected, output-disabled window
    a_r9_strobe_window: assert property (@(posedge clk) disable iff (rst)
        !pins_q.we_n |-> (!pins_q.cs_n && pins_q.oe_n));

    // R5: strobe falls only after select has already been low
    a_r5_strobe_after_select: assert property (@(posedge clk) disable iff (rst)
        $fell(pins_q.we_n) |-> ($past(!pins_q.cs_n) && $past(pins_q.oe_n)));

    // R7: the strobe edge is followed by a deselected cycle that still drives
    a_r7_hold_drive: assert property (@(posedge clk) disable iff (rst)
        $rose(pins_q.we_n) |-> (pins_q.drv && pins_q.cs_n));

    // R2: no new request is taken while busy
    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        !ready |-> !accept);

endmodule

// File: rtl/asram_rd_capture.sv
module asram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= din;
            end
        end
    end

    // R4: a single-cycle valid pulse per read
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8,
    parameter int CLK_NS = 10,
    parameter int T_RC   = 55,
    parameter int T_AA   = 55,
    parameter int T_ACS  = 55,
    parameter int T_OEA  = 25,
    parameter int T_WC   = 55,
    parameter int T_WP   = 40,
    parameter int T_DS   = 25,
    parameter int T_AW   = 50,
    parameter int T_OHZ  = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);

    localparam int RD_CYC  = read_cycles(CLK_NS, T_RC, T_AA, T_ACS, T_OEA);
    localparam int WS_CYC  = setup_cycles(CLK_NS, T_OHZ);
    localparam int WP_CYC  = strobe_cycles(CLK_NS, T_WP, T_DS, T_AW, T_WC, WS_CYC);
    localparam int LONGEST = max_of(RD_CYC, max_of(WS_CYC, WP_CYC));
    localparam int CNT_W   = max_of(1, $clog2(LONGEST + 1));

    logic             accept, load, capture, phase_done;
    logic [CNT_W-1:0] load_val;
    pin_ctl_t         pins;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    asram_phase_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (phase_done)
    );

    asram_fsm #(
        .CNT_W  (CNT_W),
        .RD_CYC (RD_CYC),
        .WS_CYC (WS_CYC),
        .WP_CYC (WP_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_done (phase_done),
        .ready      (req_ready),
        .accept     (accept),
        .load       (load),
        .load_val   (load_val),
        .capture    (capture),
        .pins       (pins)
    );

    asram_rd_capture #(
        .DATA_W (DATA_W)
    ) u_cap (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .din      (sram_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // address and write byte are held from acceptance to the next one
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    assign sram_addr   = addr_q;
    assign sram_dq_out = wdata_q;
    assign sram_cs_n   = pins.cs_n;
    assign sram_we_n   = pins.we_n;
    assign sram_oe_n   = pins.oe_n;
    assign sram_dq_oe  = pins.drv;

    // R8: address steady for as long as the RAM stays selected
    a_r8_addr_steady: assert property (@(posedge clk) disable iff (rst)
        (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

    // R6: write byte steady across the whole strobe
    a_r6_data_steady: assert property (@(posedge clk) disable iff (rst)
        (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_dq_out));

    // R2: a busy controller keeps the address it accepted
    a_r2_busy_addr: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && $past(!req_ready)) |-> $stable(sram_addr));

endmodule

// File: tb/asram_ctrl_tb.sv
`timescale 1ns/1ps
module asram_ctrl_tb;

    localparam int CLK_PERIOD = 12;
    localparam int AW = 19;
    localparam int DW = 8;
    // expected phase lengths for a 12 ns clock and the fastest grade
    localparam int EXP_RD = 5;   // ceil(55/12)
    localparam int EXP_WS = 2;   // ceil(20/12)
    localparam int EXP_WP = 4;   // max(ceil(40/12)=4, 3, 5-2, 5-2)
    localparam logic [DW-1:0] POISON = 8'hA5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rd_valid;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] sram_addr;
    logic          sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [DW-1:0] sram_dq_out;
    logic [DW-1:0] sram_dq_in = POISON;

    int checks = 0;
    int errors = 0;

    asram_ctrl #(.CLK_NS(CLK_PERIOD)) u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
        .sram_dq_in(sram_dq_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- RAM model ----------------
    logic [DW-1:0] mem [logic [AW-1:0]];
    int            rd_en_cnt = 0;
    int            wr_count  = 0;
    bit            pend = 0;
    logic [AW-1:0] paddr;
    logic [DW-1:0] pdata;

    function automatic logic [DW-1:0] model_val(input logic [AW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return a[7:0] ^ 8'h3C;
    endfunction

    always @(negedge clk) begin
        if (!rst) begin
            if (!sram_cs_n && !sram_oe_n && sram_we_n) rd_en_cnt = rd_en_cnt + 1;
            else rd_en_cnt = 0;
            sram_dq_in = (rd_en_cnt >= EXP_RD) ? model_val(sram_addr) : POISON;
            if (!sram_cs_n && !sram_we_n) begin
                pend  = 1;
                paddr = sram_addr;
                pdata = sram_dq_out;
            end else if (pend && sram_we_n) begin
                mem[paddr] = pdata;
                wr_count++;
                pend = 0;
            end
            if (!sram_oe_n && sram_dq_oe)
                check(0, "R9 driver on with oe_n low", 1, 0);
        end
    end

    // ---------------- scoreboard ----------------
    logic [DW-1:0] exp_q [$];

    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R4 unexpected rd_valid", 1, 0);
            end else begin
                logic [DW-1:0] e;
                e = exp_q.pop_front();
                check(rd_data == e, "R4 read data", rd_data, e);
            end
        end
    end

    // ---------------- driver ----------------
    task automatic present(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
        check(req_ready == 1, "R2 ready when idle", req_ready, 1);
        @(negedge clk);           // cycle 1 of the access
        req_valid = 0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        bit ok;
        present(1, a, d);
        ok = 1;
        for (int k = 1; k <= EXP_WS; k++) begin
            ok &= !sram_cs_n && sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready;
            @(negedge clk);
        end
        check(ok, "R5 write setup phase", ok, 1);
        ok = 1;
        for (int k = 1; k <= EXP_WP; k++) begin
            ok &= !sram_cs_n && sram_oe_n && !sram_we_n && sram_dq_oe && (sram_dq_out == d);
            check(sram_addr == a, "R8 address during write", sram_addr, a);
            @(negedge clk);
        end
        check(ok, "R6 write strobe phase", ok, 1);
        check(sram_cs_n && sram_we_n && sram_dq_oe && !req_ready, "R7 hold cycle",
              {sram_cs_n, sram_we_n, sram_dq_oe, req_ready}, 4'b1110);
        @(negedge clk);
        check(!sram_dq_oe && req_ready, "R7 driver off and ready", {sram_dq_oe, req_ready}, 2'b01);
    endtask

    task automatic read_body(input logic [AW-1:0] a, input bit spam, input logic [AW-1:0] sa);
        bit ok;
        ok = 1;
        for (int k = 1; k <= EXP_RD; k++) begin
            if (spam) begin
                req_valid = (k < EXP_RD); req_write = 1; req_addr = sa; req_wdata = 8'h11;
            end
            ok &= !sram_cs_n && !sram_oe_n && sram_we_n && !sram_dq_oe && !req_ready;
            check(sram_addr == a, "R8 address during read", sram_addr, a);
            @(negedge clk);
        end
        req_valid = 0;
        check(ok, spam ? "R2 busy request ignored" : "R3 read phase", ok, 1);
        check(rd_valid && req_ready && sram_cs_n && sram_oe_n, "R4 valid with ready",
              {rd_valid, req_ready, sram_cs_n, sram_oe_n}, 4'hF);
        @(negedge clk);
        check(!rd_valid, "R4 single-cycle pulse", rd_valid, 0);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        exp_q.push_back(model_val(a));
        present(0, a, '0);
        read_body(a, 0, '0);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(CLK_PERIOD * 20000);
        check(0, "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main ----------------
    initial begin
        int wc_before;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !rd_valid && req_ready,
              "R1 reset state",
              {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, rd_valid, req_ready}, 6'b111001);

        do_write(19'h00000, 8'h00);
        do_write(19'h7FFFF, 8'hFF);
        do_write(19'h12345, 8'h5A);
        do_write(19'h2AAAA, 8'hC3);

        do_read(19'h00000);
        do_read(19'h7FFFF);
        do_read(19'h12345);
        do_read(19'h2AAAA);
        do_read(19'h00777);      // never written

        // R2: request held during a read must not start a write
        wc_before = wr_count;
        exp_q.push_back(model_val(19'h12345));
        present(0, 19'h12345, '0);
        read_body(19'h12345, 1, 19'h12345);
        check(wr_count == wc_before, "R2 no write from busy request", wr_count, wc_before);
        do_read(19'h12345);

        // overwrite then read back, write directly followed by read
        do_write(19'h00000, 8'h81);
        do_read(19'h00000);
        check(wr_count == 5, "R6 write count", wr_count, 5);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R4 all reads returned", exp_q.size(), 0);
        check(sram_cs_n && !sram_dq_oe && req_ready, "R1 idle at end",
              {sram_cs_n, sram_dq_oe, req_ready}, 3'b101);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule